// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block sits between an 8-bit CPU-side access port and an external SRAM. The SRAM is reached over a multiplexed bus. Eight shared lines carry the low address byte first and then the data. Eight further lines carry the high address byte. An address-latch strobe lets an external latch capture the low byte. Active-low write and read strobes time the transfer. The bus pins are modelled as value/output-enable pairs, so that the pad ring can release them.

A small control register space configures the block. It holds a global enable, a three-bit sector limit, and one two-bit wait code for each of the two sectors. A second register holds a single-bit legacy wait mode. When the CPU raises a request, the block runs a bus sequence of four to seven timing periods. The length depends on the wait code of the addressed sector. The block holds `busy` throughout the sequence and pulses `done` in the final period, with read data already valid at that point.

The caller also says whether the following access will go to RAM. When it will, the block raises the address-latch strobe again in the final period of the current access.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `ale` are 0, `wr_n` and `rd_n` are 1, every output enable is 0, and both configuration registers read 0.
- R2: While the enable bit is 0, `ad_oe`, `a_hi_oe` and `ctl_oe` stay 0, and a request is ignored: `busy` and `done` stay 0.
- R3: While the enable bit is 1 and no access runs, `ctl_oe` and `a_hi_oe` are 1, `ad_oe` is 0, and both strobes are high.
- R4: In period 1 of an access, `ale` is 1, `ad_out` carries the low address byte with `ad_oe` set, and `a_hi` carries the high address byte. In period 2, `ale` is 0.
- R5: On a write, `ad_out` carries the write data with `ad_oe` set from period 2 through the last period in which `wr_n` is low. `wr_n` is low for 1+W periods starting at period 3, where W is the number of wait cycles. After that, `ad_oe` is 0.
- R6: On a read, `ad_oe` is 0 from period 2 to the end of the access. `rd_n` is low for 1+W periods starting at period 3. `rdata` holds the value of `ad_in` that is present in the last period with `rd_n` low.
- R7: Wait code 00 gives W=0 and 4 periods. Code 01 gives W=1 and 5 periods. Code 10 gives W=2 and 6 periods. Code 11 gives W=2 plus one idle period, 7 periods in total. `busy` is high for exactly those periods, and `done` is high only in the last one.
- R8: A limit of 0 makes every address use the upper-sector code. A limit L from 1 to 7 selects the upper code when address bits [15:13] are at least L, and the lower code otherwise.
- R9: Register 0 (`cfg_sel`=0) holds the enable in bit 7, the limit in bits 6:4, the upper-sector code in bits 3:2 and the lower-sector code in bits 1:0. Register 1 holds the legacy mode in bit 0 and the legacy wait bit in bit 1. Bits 7:2 of register 1 always read 0.
- R10: With legacy mode set, the sector codes are ignored. A legacy wait bit of 1 gives W=1 (5 periods), and a legacy wait bit of 0 gives W=0 (4 periods).
- R11: In the last period of an access, `ale` is 1 exactly when `next_ram` was 1 at request acceptance.
- R12: `wr_n` and `rd_n` are never low together. A request raised while `busy` is high is ignored and starts no later access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | Register select: 0 main, 1 legacy |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for the selected register |
| req | input | 1 | Access request, sampled while idle |
| we | input | 1 | 1 for write, 0 for read |
| addr | input | 16 | Offset within external space |
| wdata | input | 8 | Write data |
| next_ram | input | 1 | Following access also targets RAM |
| rdata | output | 8 | Read data, valid with `done` |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final period of the access |
| ad_out | output | 8 | Multiplexed address/data value |
| ad_oe | output | 1 | Output enable for `ad_out` |
| ad_in | input | 8 | Multiplexed bus read value |
| a_hi | output | 8 | High address byte |
| a_hi_oe | output | 1 | Output enable for `a_hi` |
| ale | output | 1 | Address latch enable |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| ctl_oe | output | 1 | Output enable for `ale`, `wr_n`, `rd_n` |

## Verification
The hardest behaviour to observe is the read-sampling edge. Under a wide strobe, sampling one edge early or late still returns plausible data. The bench therefore changes `ad_in` to a distinct value in every period, so the captured byte identifies the sampling edge exactly. The trailing address-latch pulse appears only on the final period, and only when `next_ram` is set. To expose it, each access is run with both values of `next_ram` under every wait code. Sector boundaries are reached by programming limits that place addresses just above and just below the boundary.

// File: rtl/xbus_pkg.sv
// Shared types for the multiplexed external bus controller.
// Assumes an 8-bit data path and a 3-bit sector-limit field.
package xbus_pkg;

    localparam int LIMIT_W = 3;
    localparam int CODE_W  = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SETUP,
        PH_STROBE,
        PH_RECOVER,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic               en;
        logic [LIMIT_W-1:0] limit;
        logic [CODE_W-1:0]  code_up;
        logic [CODE_W-1:0]  code_lo;
        logic               legacy;
        logic               legacy_wait;
    } xcfg_t;

    // Number of extra strobe cycles for a wait code.
    function automatic logic [1:0] strobe_waits(input logic [CODE_W-1:0] code);
        case (code)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/xbus_cfg.sv
// Configuration registers of the bus controller.
// Register 0: enable, sector limit, upper and lower wait codes.
// Register 1: legacy wait mode and legacy wait bit; other bits read zero.
// Assumes writes are single-cycle pulses on cfg_we.
module xbus_cfg
    import xbus_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output xcfg_t            cfg_q
);

    localparam int LIM_LSB = 2 * CODE_W;

    // Register update on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            if (!cfg_sel) begin
                cfg_q.en      <= cfg_wdata[REG_W-1];
                cfg_q.limit   <= cfg_wdata[LIM_LSB +: LIMIT_W];
                cfg_q.code_up <= cfg_wdata[CODE_W +: CODE_W];
                cfg_q.code_lo <= cfg_wdata[0 +: CODE_W];
            end else begin
                cfg_q.legacy      <= cfg_wdata[0];
                cfg_q.legacy_wait <= cfg_wdata[1];
            end
        end
    end

    // Read-back multiplexer, reserved bits forced to zero.
    always_comb begin
        cfg_rdata = '0;
        if (!cfg_sel) begin
            cfg_rdata[REG_W-1]               = cfg_q.en;
            cfg_rdata[LIM_LSB +: LIMIT_W]    = cfg_q.limit;
            cfg_rdata[CODE_W +: CODE_W]      = cfg_q.code_up;
            cfg_rdata[0 +: CODE_W]           = cfg_q.code_lo;
        end else begin
            cfg_rdata[0] = cfg_q.legacy;
            cfg_rdata[1] = cfg_q.legacy_wait;
        end
    end

endmodule

// File: rtl/xbus_sector.sv
// Wait-profile selector: picks the wait code from the addressed sector
// (or the legacy bit) and turns it into a strobe-wait count and a gap flag.
// Purely combinational; assumes the address is an offset in external space.
module xbus_sector
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  xcfg_t             cfg_q,
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        waits,
    output logic              gap
);

    localparam int TOP_LSB = ADDR_W - LIMIT_W;

    logic [LIMIT_W-1:0] addr_top;
    logic               upper;
    logic [CODE_W-1:0]  code;

    // Sector decision and code selection.
    always_comb begin
        addr_top = addr[TOP_LSB +: LIMIT_W];
        upper    = (cfg_q.limit == '0) || (addr_top >= cfg_q.limit);
        if (cfg_q.legacy)
            code = {1'b0, cfg_q.legacy_wait};
        else if (upper)
            code = cfg_q.code_up;
        else
            code = cfg_q.code_lo;
        waits = strobe_waits(code);
        gap   = (code == 2'b11);
    end

endmodule

// File: rtl/xbus_seq.sv
// Bus sequencer: runs ADDR, SETUP, STROBE (1+waits), RECOVER and an
// optional GAP period per access, drives the multiplexed bus and samples
// read data on the edge that ends the last strobe period.
// Assumes waits/gap are valid in the cycle the request is accepted.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     req,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     next_ram,
    input  logic [1:0]               waits,
    input  logic                     gap,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        rdata,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     a_hi_oe,
    output logic                     ale,
    output logic                     wr_n,
    output logic                     rd_n,
    output logic                     ctl_oe
);

    localparam int HI_W = ADDR_W - DATA_W;

    phase_e            ph;
    logic [1:0]        cnt;
    logic              we_q;
    logic              nr_q;
    logic              gap_q;
    logic [1:0]        waits_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wd_q;
    logic              accept;
    logic              last;
    logic              strobe;

    assign accept = (ph == PH_IDLE) && req && en;
    assign last   = (ph == PH_GAP) || (ph == PH_RECOVER && !gap_q);
    assign strobe = (ph == PH_STROBE);

    // Phase register and wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE:    if (accept) ph <= PH_ADDR;
                PH_ADDR:    ph <= PH_SETUP;
                PH_SETUP: begin
                    ph  <= PH_STROBE;
                    cnt <= waits_q;
                end
                PH_STROBE: begin
                    if (cnt == '0) ph <= PH_RECOVER;
                    else           cnt <= cnt - 2'd1;
                end
                PH_RECOVER: ph <= gap_q ? PH_GAP : PH_IDLE;
                default:    ph <= PH_IDLE;
            endcase
        end
    end

    // Capture of the request and its wait profile at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            nr_q    <= 1'b0;
            gap_q   <= 1'b0;
            waits_q <= '0;
            addr_q  <= '0;
            wd_q    <= '0;
        end else if (accept) begin
            we_q    <= we;
            nr_q    <= next_ram;
            gap_q   <= gap;
            waits_q <= waits;
            addr_q  <= addr;
            wd_q    <= wdata;
        end
    end

    // Read capture on the edge closing the last strobe period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (strobe && cnt == '0 && !we_q)
            rdata <= ad_in;
    end

    // Bus pin values and enables.
    always_comb begin
        busy    = (ph != PH_IDLE);
        done    = last;
        ad_out  = (ph == PH_ADDR) ? addr_q[DATA_W-1:0] : wd_q;
        ad_oe   = en && ((ph == PH_ADDR) ||
                         (we_q && (ph == PH_SETUP || strobe)));
        a_hi    = addr_q[DATA_W +: HI_W];
        a_hi_oe = en;
        ale     = (ph == PH_ADDR) || (last && nr_q);
        wr_n    = !(strobe && we_q);
        rd_n    = !(strobe && !we_q);
        ctl_oe  = en;
    end

endmodule

// File: rtl/xbus_ctrl.sv
// Multiplexed external SRAM bus controller, top level.
// Joins the configuration registers, the sector wait selector and the
// bus sequencer. Assumes the CPU offers requests only when it wants an
// external access and holds request fields stable in the request cycle.
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic                     cfg_sel,
    input  logic [DATA_W-1:0]        cfg_wdata,
    output logic [DATA_W-1:0]        cfg_rdata,
    input  logic                     req,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     next_ram,
    output logic [DATA_W-1:0]        rdata,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     a_hi_oe,
    output logic                     ale,
    output logic                     wr_n,
    output logic                     rd_n,
    output logic                     ctl_oe
);

    xcfg_t      cfg_q;
    logic [1:0] waits;
    logic       gap;

    xbus_cfg #(.REG_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_q     (cfg_q)
    );

    xbus_sector #(.ADDR_W(ADDR_W)) u_sector (
        .cfg_q (cfg_q),
        .addr  (addr),
        .waits (waits),
        .gap   (gap)
    );

    xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_q.en),
        .req      (req),
        .we       (we),
        .addr     (addr),
        .wdata    (wdata),
        .next_ram (next_ram),
        .waits    (waits),
        .gap      (gap),
        .ad_in    (ad_in),
        .rdata    (rdata),
        .busy     (busy),
        .done     (done),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .a_hi     (a_hi),
        .a_hi_oe  (a_hi_oe),
        .ale      (ale),
        .wr_n     (wr_n),
        .rd_n     (rd_n),
        .ctl_oe   (ctl_oe)
    );

endmodule

// File: rtl/xbus_ctrl_checker.sv
// Protocol checker for xbus_ctrl, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module xbus_ctrl_checker (
    input logic clk,
    input logic rst_n,
    input logic ctl_oe,
    input logic ad_oe,
    input logic a_hi_oe,
    input logic ale,
    input logic wr_n,
    input logic rd_n,
    input logic busy,
    input logic done
);

    assert_released_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_oe |-> (!ad_oe && !a_hi_oe));

    assert_strobes_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n));

    assert_read_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    assert_write_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && ctl_oe) |-> ad_oe);

    assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_addr_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && ctl_oe) |-> (ale && ad_oe && wr_n && rd_n));

endmodule

bind xbus_ctrl xbus_ctrl_checker u_xbus_ctrl_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_oe  (ctl_oe),
    .ad_oe   (ad_oe),
    .a_hi_oe (a_hi_oe),
    .ale     (ale),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .busy    (busy),
    .done    (done)
);

// File: tb/xbus_ctrl_bench.sv
// Directed bench for xbus_ctrl: one task per scenario, each self-checking.
module xbus_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        next_ram = 1'b0;
    logic [7:0]  rdata;
    logic        busy, done;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in = '0;
    logic [7:0]  a_hi;
    logic        a_hi_oe, ale, wr_n, rd_n, ctl_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xbus_ctrl u_xbus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .next_ram(next_ram), .rdata(rdata),
        .busy(busy), .done(done), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .a_hi(a_hi), .a_hi_oe(a_hi_oe), .ale(ale),
        .wr_n(wr_n), .rd_n(rd_n), .ctl_oe(ctl_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input bit sel, input logic [7:0] val);
        @(negedge clk);
        cfg_sel = sel; cfg_wdata = val; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Generic access: s strobe periods, g idle gap, optional request poke while busy.
    task automatic run_access(input bit w, input logic [15:0] a, input logic [7:0] d,
                              input bit nr, input int s, input bit g, input bit poke,
                              input string tag);
        int n;
        n = 3 + s + (g ? 1 : 0);
        @(negedge clk);
        we = w; addr = a; wdata = d; next_ram = nr; req = 1'b1;
        for (int k = 1; k <= n + 1; k++) begin
            bit stb, e_ale, e_oe;
            @(negedge clk);
            stb   = (k >= 3) && (k <= 2 + s);
            e_ale = (k == 1) || (k == n && nr);
            e_oe  = (k == 1) || (w && k >= 2 && k <= 2 + s);
            chk(busy == (k <= n), {tag, " R7 busy"}, busy, k <= n);
            chk(done == (k == n), {tag, " R7 done"}, done, k == n);
            chk(ale == e_ale, {tag, (k == n) ? " R11 ale" : " R4 ale"}, ale, e_ale);
            chk(wr_n == !(w && stb), {tag, " R5 wr_n"}, wr_n, !(w && stb));
            chk(rd_n == !(!w && stb), {tag, " R6 rd_n"}, rd_n, !(!w && stb));
            chk(ad_oe == e_oe, {tag, w ? " R5 ad_oe" : " R6 ad_oe"}, ad_oe, e_oe);
            if (k == 1) begin
                chk(ad_out == a[7:0], {tag, " R4 ad_out"}, ad_out, a[7:0]);
                chk(a_hi == a[15:8], {tag, " R4 a_hi"}, a_hi, a[15:8]);
            end else if (e_oe) begin
                chk(ad_out == d, {tag, " R5 data"}, ad_out, d);
            end
            if (k == n && !w)
                chk(rdata == 8'hA0 + 8'(2 + s), {tag, " R6 rdata"}, rdata, 8'hA0 + 2 + s);
            ad_in = 8'hA0 + 8'(k);
            if (k == 1) req = 1'b0;
            if (poke && k == 3) begin req = 1'b1; addr = 16'h1234; end
            if (poke && k == 4) req = 1'b0;
        end
        if (poke) begin
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                chk(!busy && !ale, {tag, " R12 no later access"}, busy, 0);
            end
        end
    endtask

    task automatic test_reset;
        chk(busy == 0 && done == 0 && ale == 0, "R1 status", {busy, done, ale}, 0);
        chk(wr_n && rd_n, "R1 strobes", {wr_n, rd_n}, 3);
        chk(!ad_oe && !a_hi_oe && !ctl_oe, "R1 enables", {ad_oe, a_hi_oe, ctl_oe}, 0);
        cfg_sel = 1'b0; #1;
        chk(cfg_rdata == 0, "R1 reg0", cfg_rdata, 0);
        cfg_sel = 1'b1; #1;
        chk(cfg_rdata == 0, "R1 reg1", cfg_rdata, 0);
    endtask

    task automatic test_disabled;
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 16'h4321;
        @(negedge clk);
        req = 1'b0;
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk(!busy && !done, "R2 request ignored", {busy, done}, 0);
            chk(!ad_oe && !a_hi_oe && !ctl_oe, "R2 released", {ad_oe, a_hi_oe, ctl_oe}, 0);
        end
    endtask

    task automatic test_cfg_regs;
        write_cfg(1'b0, 8'hB6);
        cfg_sel = 1'b0; #1;
        chk(cfg_rdata == 8'hB6, "R9 reg0 readback", cfg_rdata, 8'hB6);
        write_cfg(1'b1, 8'hFF);
        cfg_sel = 1'b1; #1;
        chk(cfg_rdata == 8'h03, "R9 reserved zero", cfg_rdata, 8'h03);
        write_cfg(1'b1, 8'h00);
    endtask

    task automatic test_idle_drive;
        write_cfg(1'b0, 8'h80);
        @(negedge clk);
        chk(ctl_oe && a_hi_oe && !ad_oe, "R3 idle enables", {ctl_oe, a_hi_oe, ad_oe}, 6);
        chk(wr_n && rd_n && !ale, "R3 idle strobes", {wr_n, rd_n, ale}, 6);
    endtask

    task automatic test_wait_codes;
        for (int c = 0; c < 4; c++) begin
            int s;
            s = (c == 0) ? 1 : (c == 1) ? 2 : 3;
            write_cfg(1'b0, 8'h80 | 8'(c << 2));
            run_access(1'b1, 16'h5A3C, 8'h96, 1'b0, s, c == 3, 1'b0, $sformatf("code%0d wr", c));
            run_access(1'b0, 16'hC381, 8'h00, 1'b1, s, c == 3, 1'b0, $sformatf("code%0d rd", c));
            run_access(1'b0, 16'h0102, 8'h00, 1'b0, s, c == 3, 1'b0, $sformatf("code%0d rd2", c));
        end
    endtask

    task automatic test_sectors;
        // limit 3: boundary at 0x6000; upper code 11, lower code 00
        write_cfg(1'b0, 8'h80 | (8'd3 << 4) | 8'h0C);
        run_access(1'b0, 16'h6000, 8'h00, 1'b0, 3, 1'b1, 1'b0, "R8 upper at boundary");
        run_access(1'b1, 16'h5FFF, 8'h3C, 1'b0, 1, 1'b0, 1'b0, "R8 lower below boundary");
        // limit 7: upper code 01, lower code 10
        write_cfg(1'b0, 8'h80 | (8'd7 << 4) | 8'h06);
        run_access(1'b0, 16'hE000, 8'h00, 1'b1, 2, 1'b0, 1'b0, "R8 upper top");
        run_access(1'b1, 16'hDFFF, 8'h55, 1'b1, 3, 1'b0, 1'b0, "R8 lower top");
        // limit 0: one sector, upper code 10, lower code 11
        write_cfg(1'b0, 8'h80 | 8'h0B);
        run_access(1'b0, 16'h0000, 8'h00, 1'b0, 3, 1'b0, 1'b0, "R8 single sector low");
        run_access(1'b1, 16'hFFFF, 8'hAA, 1'b0, 3, 1'b0, 1'b0, "R8 single sector high");
    endtask

    task automatic test_legacy;
        write_cfg(1'b0, 8'h80 | (8'd1 << 4) | 8'h0F);
        write_cfg(1'b1, 8'h03);
        run_access(1'b1, 16'h8000, 8'h71, 1'b0, 2, 1'b0, 1'b0, "R10 legacy wait on");
        write_cfg(1'b1, 8'h01);
        run_access(1'b0, 16'h0010, 8'h00, 1'b1, 1, 1'b0, 1'b0, "R10 legacy wait off");
        write_cfg(1'b1, 8'h00);
    endtask

    task automatic test_busy_poke;
        write_cfg(1'b0, 8'h80 | 8'h08);
        run_access(1'b1, 16'h2222, 8'h19, 1'b0, 3, 1'b0, 1'b1, "R12 poke");
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset;
        rst_n = 1'b1;
        @(negedge clk);
        test_reset;
        test_disabled;
        test_cfg_regs;
        test_idle_drive;
        test_wait_codes;
        test_sectors;
        test_legacy;
        test_busy_poke;
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule